// File: doc/BRIEF.md
# DMA Status and Interrupt Register Bank

This block is the software-visible control and status word file of an Ethernet DMA controller. A single bus port carries a byte address, a write enable and write data, and returns read data combinationally. The byte address is turned into a word index. Words below the bank limit are stored. A handful of words have special write behaviour: the bus mode word, the two descriptor list bases, the transmit poll word and the event status word.

The transmit and receive engines sit outside the bank. They report completions and buffer shortages as one-cycle event pulses. Those pulses set bits in the status word, and software clears the bits by writing ones to them. A level interrupt is raised whenever a status bit is set and its matching enable bit is set. When software writes a list base, the bank also loads the matching current descriptor pointer and pulses a load strobe. When software writes the poll word, the bank pulses a start strobe to the transmit engine.

Top module: `dma_csr_bank`

## Requirements
- R1: The word index is the byte address shifted right by two, so the two lowest address bits have no effect on which word is read or written.
- R2: A write to the status word (index 0x3C5, byte 0xF14) clears every status bit that is 1 in the written data and leaves the other bits unchanged.
- R3: The transmit-done event sets status bits 0 and 16. The receive-done event sets bits 6 and 16. The receive-no-buffer event sets bits 7 and 15. If an event and a clearing write hit the same bit in one cycle, the bit ends up set.
- R4: `irq` is high exactly when the bitwise AND of the status word and the enable word (index 0x3C7, byte 0xF1C) is nonzero. It reflects the registered values, so it changes in the cycle after the write or event that changes them.
- R5: A write to the receive list base (index 0x3C3) stores the value there and in the receive current pointer (index 0x3D3). A write to the transmit list base (index 0x3C4) stores the value there and in the transmit current pointer (index 0x3D2). In both cases the matching load strobe is high for exactly the one cycle after the write edge.
- R6: A write to the bus mode word (index 0x3C0) stores the data with bit 0 forced to 0.
- R7: A write to the poll word (index 0x3C1) stores nothing, so that word keeps reading 0. `tx_poll` is high for exactly the one cycle after the write edge.
- R8: Index 8 always reads 0x1012, whatever has been written to it.
- R9: Indices at or above 0x400 are never stored and read as 0. Such a write does not alter any in-range word.
- R10: Reset (synchronous, active high) clears every word, the status word and all strobes to 0.
- R11: Any other in-range word, including the control word at index 0x3C6, reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address for the read and the write |
| wr_en | input | 1 | Write strobe for the current address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| ev_tx_done | input | 1 | Transmit engine finished a frame (pulse) |
| ev_rx_done | input | 1 | Receive engine delivered a frame (pulse) |
| ev_rx_nobuf | input | 1 | Receive engine found no free descriptor (pulse) |
| irq | output | 1 | Level interrupt |
| tx_poll | output | 1 | One-cycle start pulse to the transmit engine |
| rx_base_load | output | 1 | One-cycle pulse: receive current pointer reloaded |
| tx_base_load | output | 1 | One-cycle pulse: transmit current pointer reloaded |

## Verification
The assertions assume that event pulses and bus writes come only when reset is low. They also assume that the enable word changes only through a bus write. For that reason the interrupt properties apply only in cycles with no write. The bench changes every input on the falling clock edge and holds each event for one cycle. It never writes the enable word in the same cycle as an event, except in the one deliberate collision, which is a status write against a transmit-done event.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int DATA_W = 32;

  // word indices whose behaviour is special
  localparam int IDX_VERSION = 'h008;
  localparam int IDX_BUSMODE = 'h3C0;
  localparam int IDX_TXPOLL  = 'h3C1;
  localparam int IDX_RXBASE  = 'h3C3;
  localparam int IDX_TXBASE  = 'h3C4;
  localparam int IDX_STATUS  = 'h3C5;
  localparam int IDX_INTEN   = 'h3C7;
  localparam int IDX_TXCUR   = 'h3D2;
  localparam int IDX_RXCUR   = 'h3D3;

  localparam logic [DATA_W-1:0] VERSION_WORD = 32'h0000_1012;

  // status bit positions
  localparam int ST_TXDONE  = 0;
  localparam int ST_RXDONE  = 6;
  localparam int ST_RXNOBUF = 7;
  localparam int ST_ABNSUM  = 15;
  localparam int ST_NRMSUM  = 16;

  function automatic logic [DATA_W-1:0] event_set_mask(input logic tx_done,
                                                       input logic rx_done,
                                                       input logic rx_nobuf);
    logic [DATA_W-1:0] m;
    m = '0;
    m[ST_TXDONE]  = tx_done;
    m[ST_RXDONE]  = rx_done;
    m[ST_RXNOBUF] = rx_nobuf;
    m[ST_NRMSUM]  = tx_done | rx_done;
    m[ST_ABNSUM]  = rx_nobuf;
    return m;
  endfunction

  // clear-by-one, then set: a same-cycle set overrides the clear
  function automatic logic [DATA_W-1:0] w1c_next(input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] clr,
                                                 input logic [DATA_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [DATA_W-1:0] bus_mode_store(input logic [DATA_W-1:0] v);
    return {v[DATA_W-1:1], 1'b0};
  endfunction

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode #(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SLOT_W-1:0] slot,
  output logic              in_range
);
  logic [ADDR_W-1:0] word_idx;

  always_comb begin
    word_idx = addr >> 2;
    slot     = word_idx[SLOT_W-1:0];
    in_range = ~|word_idx[ADDR_W-1:SLOT_W];
  end
endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status
  import dma_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_rx_nobuf,
  input  logic [DATA_W-1:0] inten,
  output logic [DATA_W-1:0] status_q,
  output logic              irq
);
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] clr_mask;

  always_comb begin
    set_mask = event_set_mask(ev_tx_done, ev_rx_done, ev_rx_nobuf);
    clr_mask = clr_wr ? clr_data : '0;
    irq      = |(status_q & inten);
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= w1c_next(status_q, clr_mask, set_mask);
  end
endmodule

// File: rtl/dma_csr_store.sv
module dma_csr_store
  import dma_csr_pkg::*;
#(
  parameter int NUM_WORDS = 1024,
  parameter int SLOT_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] inten,
  output logic [DATA_W-1:0] rx_base_q,
  output logic [DATA_W-1:0] rx_cur_q,
  output logic              tx_poll_q,
  output logic              rx_load_q,
  output logic              tx_load_q
);
  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic hit_poll, hit_rxb, hit_txb, hit_bus, hit_stat;

  always_comb begin
    hit_poll  = wr_ok && (slot == SLOT_W'(IDX_TXPOLL));
    hit_rxb   = wr_ok && (slot == SLOT_W'(IDX_RXBASE));
    hit_txb   = wr_ok && (slot == SLOT_W'(IDX_TXBASE));
    hit_bus   = wr_ok && (slot == SLOT_W'(IDX_BUSMODE));
    hit_stat  = wr_ok && (slot == SLOT_W'(IDX_STATUS));
    rd_word   = mem[slot];
    inten     = mem[IDX_INTEN];
    rx_base_q = mem[IDX_RXBASE];
    rx_cur_q  = mem[IDX_RXCUR];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
      tx_poll_q <= 1'b0;
      rx_load_q <= 1'b0;
      tx_load_q <= 1'b0;
    end else begin
      tx_poll_q <= hit_poll;
      rx_load_q <= hit_rxb;
      tx_load_q <= hit_txb;
      if (hit_bus) begin
        mem[IDX_BUSMODE] <= bus_mode_store(wr_data);
      end else if (hit_rxb) begin
        mem[IDX_RXBASE] <= wr_data;
        mem[IDX_RXCUR]  <= wr_data;
      end else if (hit_txb) begin
        mem[IDX_TXBASE] <= wr_data;
        mem[IDX_TXCUR]  <= wr_data;
      end else if (wr_ok && !hit_poll && !hit_stat) begin
        mem[slot] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_rx_nobuf,
  output logic              irq,
  output logic              tx_poll,
  output logic              rx_base_load,
  output logic              tx_base_load
);
  localparam int SLOT_W = $clog2(NUM_WORDS);

  logic [SLOT_W-1:0] slot;
  logic              in_range;
  logic              wr_ok;
  logic              status_wr;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] inten_q;
  logic [DATA_W-1:0] store_rd;
  logic [DATA_W-1:0] rx_base_q;
  logic [DATA_W-1:0] rx_cur_q;

  dma_csr_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_dec (
    .addr(addr), .slot(slot), .in_range(in_range)
  );

  always_comb begin
    wr_ok     = wr_en && in_range;
    status_wr = wr_ok && (slot == SLOT_W'(IDX_STATUS));
  end

  dma_csr_store #(.NUM_WORDS(NUM_WORDS), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .slot(slot), .wr_data(wr_data),
    .rd_word(store_rd), .inten(inten_q), .rx_base_q(rx_base_q),
    .rx_cur_q(rx_cur_q), .tx_poll_q(tx_poll), .rx_load_q(rx_base_load),
    .tx_load_q(tx_base_load)
  );

  dma_csr_status u_stat (
    .clk(clk), .rst(rst), .clr_wr(status_wr), .clr_data(wr_data),
    .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_rx_nobuf(ev_rx_nobuf),
    .inten(inten_q), .status_q(status_q), .irq(irq)
  );

  always_comb begin
    if (!in_range)                          rd_data = '0;
    else if (slot == SLOT_W'(IDX_VERSION))  rd_data = VERSION_WORD;
    else if (slot == SLOT_W'(IDX_STATUS))   rd_data = status_q;
    else                                    rd_data = store_rd;
  end
endmodule

// File: rtl/dma_csr_bank_chk.sv
module dma_csr_bank_chk
  import dma_csr_pkg::*;
#(
  parameter int SLOT_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              in_range,
  input logic [SLOT_W-1:0] slot,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              ev_tx_done,
  input logic              ev_rx_done,
  input logic              ev_rx_nobuf,
  input logic [31:0]       status_q,
  input logic [31:0]       inten_q,
  input logic              irq,
  input logic              tx_poll,
  input logic              rx_base_load,
  input logic [31:0]       rx_base_q,
  input logic [31:0]       rx_cur_q
);
  logic ev_any;
  assign ev_any = ev_tx_done | ev_rx_done | ev_rx_nobuf;

  a_r2_w1c_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_range && slot == SLOT_W'(IDX_STATUS) && !ev_any)
    |=> status_q == ($past(status_q) & ~$past(wr_data)));

  a_r3_rx_done_sets: assert property (@(posedge clk) disable iff (rst)
    ev_rx_done |=> (status_q[ST_RXDONE] && status_q[ST_NRMSUM]));

  a_r3_nobuf_sets: assert property (@(posedge clk) disable iff (rst)
    ev_rx_nobuf |=> (status_q[ST_RXNOBUF] && status_q[ST_ABNSUM]));

  a_r4_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (ev_tx_done && inten_q[ST_TXDONE] && !wr_en) |=> irq);

  a_r4_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (inten_q == 32'h0 && !wr_en) |=> !irq);

  a_r5_rx_ptr_load: assert property (@(posedge clk) disable iff (rst)
    rx_base_load |-> (rx_cur_q == rx_base_q));

  a_r7_poll_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_range && slot == SLOT_W'(IDX_TXPOLL)) |=> tx_poll);

  a_r8_version_word: assert property (@(posedge clk) disable iff (rst)
    (in_range && slot == SLOT_W'(IDX_VERSION)) |-> rd_data == VERSION_WORD);

  a_r9_out_of_range_zero: assert property (@(posedge clk) disable iff (rst)
    !in_range |-> rd_data == 32'h0);
endmodule

bind dma_csr_bank dma_csr_bank_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .in_range(in_range), .slot(slot),
  .wr_data(wr_data), .rd_data(rd_data), .ev_tx_done(ev_tx_done),
  .ev_rx_done(ev_rx_done), .ev_rx_nobuf(ev_rx_nobuf), .status_q(status_q),
  .inten_q(inten_q), .irq(irq), .tx_poll(tx_poll), .rx_base_load(rx_base_load),
  .rx_base_q(rx_base_q), .rx_cur_q(rx_cur_q)
);

// File: tb/dma_csr_bank_bench.sv
module dma_csr_bank_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        ev_tx_done, ev_rx_done, ev_rx_nobuf;
  logic        irq, tx_poll, rx_base_load, tx_base_load;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_csr_bank u_dma_csr_bank (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
    .ev_rx_nobuf(ev_rx_nobuf), .irq(irq), .tx_poll(tx_poll),
    .rx_base_load(rx_base_load), .tx_base_load(tx_base_load)
  );

  // {is_read, byte address, data or expected, requirement number}
  localparam int NV = 19;
  localparam logic [52:0] VECS [NV] = '{
    {1'b0, 16'h0F00, 32'hFFFF_FFFF, 4'd6},   // R6 bus mode write
    {1'b1, 16'h0F00, 32'hFFFF_FFFE, 4'd6},   // R6 bit 0 reads 0
    {1'b0, 16'h0F0C, 32'h1000_0040, 4'd5},   // R5 rx list base
    {1'b1, 16'h0F4C, 32'h1000_0040, 4'd5},   // R5 rx current pointer
    {1'b1, 16'h0F0C, 32'h1000_0040, 4'd5},
    {1'b0, 16'h0F10, 32'h2000_0080, 4'd5},   // R5 tx list base
    {1'b1, 16'h0F48, 32'h2000_0080, 4'd5},   // R5 tx current pointer
    {1'b0, 16'h0020, 32'h0000_DEAD, 4'd8},   // R8 write to version word
    {1'b1, 16'h0020, 32'h0000_1012, 4'd8},
    {1'b0, 16'h0103, 32'h1234_5678, 4'd1},   // R1 low address bits ignored
    {1'b1, 16'h0100, 32'h1234_5678, 4'd11},  // R11 plain storage
    {1'b1, 16'h0102, 32'h1234_5678, 4'd1},
    {1'b0, 16'h1000, 32'hAAAA_AAAA, 4'd9},   // R9 out of range write
    {1'b1, 16'h1000, 32'h0000_0000, 4'd9},
    {1'b1, 16'h0000, 32'h0000_0000, 4'd9},   // R9 no alias onto word 0
    {1'b0, 16'h0F18, 32'h0000_2002, 4'd11},  // R11 control word
    {1'b1, 16'h0F18, 32'h0000_2002, 4'd11},
    {1'b0, 16'h0F04, 32'hFFFF_FFFF, 4'd7},   // R7 poll word
    {1'b1, 16'h0F04, 32'h0000_0000, 4'd7}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic pulse(input logic t, input logic r, input logic n);
    @(negedge clk);
    ev_tx_done = t; ev_rx_done = r; ev_rx_nobuf = n;
    @(negedge clk);
    ev_tx_done = 0; ev_rx_done = 0; ev_rx_nobuf = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1; wr_en = 0; addr = '0; wr_data = '0;
    ev_tx_done = 0; ev_rx_done = 0; ev_rx_nobuf = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R10 state after reset
    rd(16'h0F00, v); chk("R10 bus mode after reset", v, 32'h0);
    rd(16'h0F14, v); chk("R10 status after reset", v, 32'h0);
    chk("R10 irq after reset", {31'h0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][52]) begin
        rd(VECS[i][51:36], v);
        chk($sformatf("R%0d vector %0d", VECS[i][3:0], i), v, VECS[i][35:4]);
      end else begin
        wr(VECS[i][51:36], VECS[i][35:4]);
      end
    end

    // R5 and R7 strobe width
    wr(16'h0F0C, 32'h3000_0000);
    #1 chk("R5 rx load strobe high", {31'h0, rx_base_load}, 32'h1);
    @(negedge clk); #1 chk("R5 rx load strobe low", {31'h0, rx_base_load}, 32'h0);
    wr(16'h0F10, 32'h4000_0000);
    #1 chk("R5 tx load strobe high", {31'h0, tx_base_load}, 32'h1);
    @(negedge clk); #1 chk("R5 tx load strobe low", {31'h0, tx_base_load}, 32'h0);
    wr(16'h0F04, 32'h1);
    #1 chk("R7 poll pulse high", {31'h0, tx_poll}, 32'h1);
    @(negedge clk); #1 chk("R7 poll pulse low", {31'h0, tx_poll}, 32'h0);

    // R3 events and R4 interrupt
    pulse(1, 0, 0);
    rd(16'h0F14, v); chk("R3 tx done bits", v, 32'h0001_0001);
    chk("R4 irq masked", {31'h0, irq}, 32'h0);
    wr(16'h0F1C, 32'h1);
    #1 chk("R4 irq after enable", {31'h0, irq}, 32'h1);
    wr(16'h0F14, 32'h1);
    rd(16'h0F14, v); chk("R2 clear bit 0 only", v, 32'h0001_0000);
    chk("R4 irq after clear", {31'h0, irq}, 32'h0);
    pulse(0, 0, 1);
    rd(16'h0F14, v); chk("R3 no-buffer bits", v, 32'h0001_8080);
    pulse(0, 1, 0);
    rd(16'h0F14, v); chk("R3 rx done bits", v, 32'h0001_80C0);

    // R3 set wins over a same-cycle clear
    @(negedge clk);
    addr = 16'h0F14; wr_data = 32'hFFFF_FFFF; wr_en = 1; ev_tx_done = 1;
    @(negedge clk);
    wr_en = 0; ev_tx_done = 0;
    rd(16'h0F14, v); chk("R3 set beats clear", v, 32'h0001_0001);
    chk("R4 irq set again", {31'h0, irq}, 32'h1);
    wr(16'h0F1C, 32'h80);
    #1 chk("R4 irq enable moved off", {31'h0, irq}, 32'h0);

    // R10 reset clears stored words
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    rd(16'h0F00, v); chk("R10 bus mode cleared", v, 32'h0);
    rd(16'h0F4C, v); chk("R10 rx pointer cleared", v, 32'h0);
    rd(16'h0100, v); chk("R10 storage cleared", v, 32'h0);
    rd(16'h0F1C, v); chk("R10 enable cleared", v, 32'h0);
    rd(16'h0F14, v); chk("R10 status cleared", v, 32'h0);
    chk("R10 irq cleared", {31'h0, irq}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule